// File: doc/BRIEF.md
# Converter Result Read-Out Slave

This block sits between a sigma-delta converter core and a two-wire serial bus (I2C). It only answers read requests. When a conversion finishes, the block captures the core's sample, packs it into a 32-bit word and waits in a sleep state. When a master addresses it for reading, it moves into data output and shifts the word out as four bytes, most significant bit first, on an open-drain data line.

The device address comes from two three-level strap inputs. The block also answers one fixed global address, which a system uses to address several converters at once. A new conversion starts when the master has clocked out the whole word, or when the master ends the transfer early with a STOP at a byte boundary. The conversion is modelled by a counter that raises a done strobe a set number of cycles after it starts.

The 32-bit word carries two leading flag bits, then the result in two's complement, then sub-LSB bits. The flag bits mark an input above positive full scale or below negative full scale, and the result field is clamped in both cases.

Top module: `cvr_i2c_result_slave`

## Requirements
- R1: After reset the block is converting (mode code 0) and does not drive SDA.
- R2: The mode changes from converting to sleep (code 1) CONV_CYCLES cycles after the conversion starts, and not earlier.
- R3: Strap codes are 00 low, 01 high, 10 floating. The (strap_a, strap_b) pairs give these 7-bit addresses: (low,high) 0x14, (low,float) 0x15, (float,high) 0x17, (float,float) 0x24, (high,high) 0x26, (high,float) 0x27. Any other pair has no local address.
- R4: A read request to address 0x77 is acknowledged in the same way as a request to the local address.
- R5: The block NAKs an address byte whose R/W bit is 0. It also NAKs a read request that arrives while a conversion is running.
- R6: For a sample s with -2^29 <= s <= 2^29-1, the word is {~s[29], s[29], s[29:0]}. Its 24 result bits are s[29:6] and its six sub-LSB bits are s[5:0].
- R7: For a sample above 2^29-1 the word is 0xC000_0000: both flag bits are 1 and everything after them is 0.
- R8: For a sample below -2^29 the word is 0x3FFF_FFFF: both flag bits are 0 and everything after them is 1.
- R9: The word goes out as four bytes, bit 31 first. A new conversion (mode 0) starts at the end of the acknowledge slot of the fourth byte.
- R10: A STOP that arrives after an acknowledge slot, before the next data bit has finished, ends data output and starts a new conversion.
- R11: A STOP inside a data byte is ignored. The block stays in data output (mode 2), and the next read restarts the word at bit 31.
- R12: Once the block has acknowledged a read address, the mode is data output (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| strap_a_i | input | 2 | First address strap (00 low, 01 high, 10 float) |
| strap_b_i | input | 2 | Second address strap (00 low, 01 high, 10 float) |
| sample_i | input | IN_W | Signed converter sample, captured when the conversion finishes |
| mode_o | output | 2 | 0 converting, 1 sleep, 2 data output |

## Verification
The hardest case to reach is a STOP inside a data byte. A STOP needs SDA to rise while SCL is high, so the slave must be releasing the line at that moment. The stimulus loads an overrange sample, whose first two word bits are both 1. The master reads one bit and then issues a STOP while the slave is presenting the second bit, which is also a released line. The abort path is reached separately: the master NAKs the first byte and then issues a STOP at that byte boundary.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

  localparam logic [1:0] STRAP_LOW   = 2'b00;
  localparam logic [1:0] STRAP_HIGH  = 2'b01;
  localparam logic [1:0] STRAP_FLOAT = 2'b10;

  localparam logic [6:0] GLOBAL_ADDR = 7'h77;

  typedef enum logic [1:0] {
    CV_CONVERT = 2'd0,
    CV_SLEEP   = 2'd1,
    CV_OUTPUT  = 2'd2
  } cvr_mode_e;

  typedef enum logic [2:0] {
    PB_IDLE = 3'd0,
    PB_ADDR = 3'd1,
    PB_AACK = 3'd2,
    PB_TX   = 3'd3,
    PB_TACK = 3'd4,
    PB_WAIT = 3'd5
  } cvr_proto_e;

endpackage

// File: rtl/cvr_bus_sync.sv
module cvr_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic                   scl_prev_q, sda_prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        scl_pipe_d = scl_i;
        sda_pipe_d = sda_i;
      end
    end else begin : g_many
      always_comb begin
        scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[SYNC_STAGES-1];
      sda_prev_q <= sda_pipe_q[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_pipe_q[SYNC_STAGES-1];
  assign sda_o      = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/cvr_addr_decode.sv
module cvr_addr_decode
  import cvr_pkg::*;
(
  input  logic [1:0] strap_a_i,
  input  logic [1:0] strap_b_i,
  output logic [6:0] addr_o,
  output logic       valid_o
);

  always_comb begin
    addr_o  = 7'h00;
    valid_o = 1'b1;
    case ({strap_a_i, strap_b_i})
      {STRAP_LOW,   STRAP_HIGH}:  addr_o = 7'h14;
      {STRAP_LOW,   STRAP_FLOAT}: addr_o = 7'h15;
      {STRAP_FLOAT, STRAP_HIGH}:  addr_o = 7'h17;
      {STRAP_FLOAT, STRAP_FLOAT}: addr_o = 7'h24;
      {STRAP_HIGH,  STRAP_HIGH}:  addr_o = 7'h26;
      {STRAP_HIGH,  STRAP_FLOAT}: addr_o = 7'h27;
      default:                    valid_o = 1'b0;
    endcase
  end

  // R3: a strap_b tied low never yields a local address
  always_comb begin
    assert_b_low_unmapped_R3: assert (!(valid_o && strap_b_i == STRAP_LOW));
  end

endmodule

// File: rtl/cvr_frame_fmt.sv
module cvr_frame_fmt #(
  parameter int IN_W  = 32,
  parameter int RES_W = 24,
  parameter int SUB_W = 6,
  localparam int CODE_W  = RES_W + SUB_W,
  localparam int FRAME_W = CODE_W + 2
) (
  input  logic signed [IN_W-1:0]    sample_i,
  output logic        [FRAME_W-1:0] frame_o
);

  localparam logic signed [IN_W-1:0] POS_LIM =
    $signed({{(IN_W-CODE_W+1){1'b0}}, {(CODE_W-1){1'b1}}});
  localparam logic signed [IN_W-1:0] NEG_LIM =
    $signed({{(IN_W-CODE_W+1){1'b1}}, {(CODE_W-1){1'b0}}});

  logic above, below, sgn;

  always_comb begin
    above = sample_i > POS_LIM;
    below = sample_i < NEG_LIM;
    sgn   = sample_i[CODE_W-1];
    if (above)      frame_o = {2'b11, {CODE_W{1'b0}}};
    else if (below) frame_o = {2'b00, {CODE_W{1'b1}}};
    else            frame_o = {~sgn, sgn, sample_i[CODE_W-1:0]};
  end

endmodule

// File: rtl/cvr_conv_timer.sv
module cvr_conv_timer #(
  parameter int CONV_CYCLES = 4096,
  localparam int CW = $clog2(CONV_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  output logic done_o
);

  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R2: the done strobe ends the busy period
  assert_done_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_q |-> !busy_q);

endmodule

// File: rtl/cvr_i2c_result_slave.sv
module cvr_i2c_result_slave
  import cvr_pkg::*;
#(
  parameter int CONV_CYCLES = 4096,
  parameter int IN_W        = 32,
  parameter int RES_W       = 24,
  parameter int SUB_W       = 6,
  localparam int FRAME_W    = RES_W + SUB_W + 2,
  localparam int PTR_W      = $clog2(FRAME_W)
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [1:0]      strap_a_i,
  input  logic [1:0]      strap_b_i,
  input  logic [IN_W-1:0] sample_i,
  output logic [1:0]      mode_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= 2'b00;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  cvr_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_s),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  logic [6:0] own_addr;
  logic       own_valid;

  cvr_addr_decode u_addr (
    .strap_a_i (strap_a_i),
    .strap_b_i (strap_b_i),
    .addr_o    (own_addr),
    .valid_o   (own_valid)
  );

  logic [FRAME_W-1:0] fmt_frame;

  cvr_frame_fmt #(.IN_W(IN_W), .RES_W(RES_W), .SUB_W(SUB_W)) u_fmt (
    .sample_i (sample_i),
    .frame_o  (fmt_frame)
  );

  logic conv_start, conv_done;

  cvr_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .start_i (conv_start),
    .done_o  (conv_done)
  );

  cvr_mode_e          mode_q, mode_d;
  cvr_proto_e         pst_q, pst_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [7:0]         shreg_q, shreg_d;
  logic               oe_q, oe_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d, ptr_dec;
  logic               last_q, last_d;
  logic               nak_q, nak_d;
  logic               bnd_q, bnd_d;
  logic               addr_hit;

  assign ptr_dec  = ptr_q - 1'b1;
  assign addr_hit = shreg_q[0] && (mode_q != CV_CONVERT) &&
                    ((own_valid && shreg_q[7:1] == own_addr) ||
                     shreg_q[7:1] == GLOBAL_ADDR);

  always_comb begin
    mode_d  = mode_q;
    pst_d   = pst_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    oe_d    = oe_q;
    frame_d = frame_q;
    ptr_d   = ptr_q;
    last_d  = last_q;
    nak_d   = nak_q;
    bnd_d   = bnd_q;

    if (conv_done) begin
      mode_d  = CV_SLEEP;
      frame_d = fmt_frame;
    end

    if (bus_start) begin
      pst_d = PB_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
      bnd_d = 1'b0;
    end else if (bus_stop) begin
      pst_d = PB_IDLE;
      oe_d  = 1'b0;
      bnd_d = 1'b0;
      if (mode_q == CV_OUTPUT && bnd_q) mode_d = CV_CONVERT;
    end else begin
      case (pst_q)
        PB_ADDR: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == 4'd8) begin
            if (addr_hit) begin
              oe_d   = 1'b1;
              pst_d  = PB_AACK;
              mode_d = CV_OUTPUT;
              ptr_d  = PTR_W'(FRAME_W - 1);
            end else begin
              pst_d = PB_WAIT;
            end
          end
        end
        PB_AACK: begin
          if (scl_fall) begin
            pst_d = PB_TX;
            cnt_d = '0;
            oe_d  = ~frame_q[ptr_q];
            bnd_d = 1'b1;
          end
        end
        PB_TX: begin
          if (scl_rise) cnt_d = cnt_q + 1'b1;
          if (scl_fall) begin
            bnd_d = 1'b0;
            ptr_d = ptr_dec;
            if (cnt_q == 4'd8) begin
              oe_d   = 1'b0;
              pst_d  = PB_TACK;
              last_d = (ptr_q == '0);
            end else begin
              oe_d = ~frame_q[ptr_dec];
            end
          end
        end
        PB_TACK: begin
          if (scl_rise) nak_d = sda_s;
          if (scl_fall) begin
            bnd_d = 1'b1;
            if (last_q) begin
              mode_d = CV_CONVERT;
              pst_d  = PB_WAIT;
            end else if (nak_q) begin
              pst_d = PB_WAIT;
            end else begin
              pst_d = PB_TX;
              cnt_d = '0;
              oe_d  = ~frame_q[ptr_q];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign conv_start = (mode_q != CV_CONVERT) && (mode_d == CV_CONVERT);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q  <= CV_CONVERT;
      pst_q   <= PB_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      oe_q    <= 1'b0;
      frame_q <= '0;
      ptr_q   <= '0;
      last_q  <= 1'b0;
      nak_q   <= 1'b0;
      bnd_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pst_q   <= pst_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      oe_q    <= oe_d;
      frame_q <= frame_d;
      ptr_q   <= ptr_d;
      last_q  <= last_d;
      nak_q   <= nak_d;
      bnd_q   <= bnd_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign mode_o   = mode_q;

  // R5: the line stays released for the whole conversion
  assert_quiet_while_converting_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    mode_q == CV_CONVERT |-> !oe_q);

  // R12: the address acknowledge happens only in data output
  assert_ack_in_output_R12: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    pst_q == PB_AACK |-> mode_q == CV_OUTPUT);

  // R2: the timer strobe moves the mode to sleep
  assert_done_to_sleep_R2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    conv_done |=> mode_q == CV_SLEEP);

  // R10: data output ends only at a byte boundary or after the final byte
  assert_leave_output_at_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ($past(mode_q) == CV_OUTPUT && mode_q == CV_CONVERT) |-> ($past(bnd_q) || $past(last_q)));

  // R9: SDA is changed only while SCL is low, except when a bus condition releases it
  assert_sda_moves_with_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!$stable(oe_q) && !$past(bus_start) && !$past(bus_stop)) |-> !$past(scl_s));

endmodule

// File: tb/cvr_i2c_result_slave_bench.sv
module cvr_i2c_result_slave_bench;

  localparam int CONV = 2000;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m;
  logic sda_oe;
  logic [1:0] strap_a, strap_b, mode;
  logic signed [31:0] sample;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  cvr_i2c_result_slave #(.CONV_CYCLES(CONV)) u_cvr_i2c_result_slave (
    .clk_i    (clk),
    .rst_n_i  (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .strap_a_i(strap_a),
    .strap_b_i(strap_b),
    .sample_i (sample),
    .mode_o   (mode)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] model_word(logic signed [31:0] s);
    if (s > 32'sh1FFF_FFFF)       return 32'hC000_0000;
    else if (s < -32'sh2000_0000) return 32'h3FFF_FFFF;
    else                          return {~s[29], s[29], s[29:0]};
  endfunction

  task automatic push_bytes(logic [31:0] w, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(w[31-8*i -: 8]);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; tk(Q);
    scl = 1'b0;   tk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tk(Q);
    scl = 1'b1;   tk(Q);
    sda_m = 1'b1; tk(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tk(Q);
    scl = 1'b1; tk(2*Q);
    scl = 1'b0; tk(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tk(Q);
    scl = 1'b1; tk(Q);
    b = sda_line; tk(Q);
    scl = 1'b0; tk(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(x);
    ack = ~x;
  endtask

  // monitor side of the scoreboard: each received byte is compared with the queue head
  task automatic recv_byte(logic nak, string req);
    logic [7:0] v;
    logic [7:0] e;
    logic x;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(x);
      v[i] = x;
    end
    send_bit(nak);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    check(req, {24'h0, v}, {24'h0, e});
  endtask

  task automatic wait_sleep(string req);
    int k = 0;
    while (mode !== 2'd1 && k < 3*CONV) begin
      tk(1);
      k++;
    end
    check(req, {30'h0, mode}, 32'd1);
  endtask

  task automatic read_word(logic [6:0] a, string req);
    logic ack;
    push_bytes(model_word(sample), 4);
    bus_start();
    send_byte({a, 1'b1}, ack);
    check({req, " ack"}, {31'h0, ack}, 32'd1);
    check("R12 mode after ack", {30'h0, mode}, 32'd2);
    for (int i = 0; i < 4; i++) recv_byte(i == 3, req);
    bus_stop();
    check("R9 new conversion after word", {30'h0, mode}, 32'd0);
  endtask

  initial begin
    logic ack, bit0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    strap_a = 2'b00; strap_b = 2'b01;
    sample = 32'sd12345;
    tk(5);
    rst_n = 1'b1;
    tk(3);
    check("R1 mode after reset", {30'h0, mode}, 32'd0);
    check("R1 sda released", {31'h0, sda_oe}, 32'd0);

    bus_start();
    send_byte({7'h14, 1'b1}, ack);
    check("R5 read while converting", {31'h0, ack}, 32'd0);
    bus_stop();
    tk(600);
    check("R2 not early", {30'h0, mode}, 32'd0);
    wait_sleep("R2 sleep after conversion");

    bus_start();
    send_byte({7'h14, 1'b0}, ack);
    check("R5 write address", {31'h0, ack}, 32'd0);
    bus_stop();
    check("R5 mode kept", {30'h0, mode}, 32'd1);

    read_word(7'h14, "R6 R3 in-range word");

    sample = 32'sh2000_0000;
    wait_sleep("R2");
    read_word(7'h77, "R4 R7 overrange word");

    sample = -32'sh2000_0001;
    strap_a = 2'b01; strap_b = 2'b10;
    wait_sleep("R2");
    read_word(7'h27, "R3 R8 underrange word");

    sample = -32'sd5;
    wait_sleep("R2");
    exp_q.push_back(8'h7F);
    bus_start();
    send_byte({7'h27, 1'b1}, ack);
    recv_byte(1'b1, "R10 first byte");
    bus_stop();
    check("R10 abort starts conversion", {30'h0, mode}, 32'd0);

    sample = 32'sh4000_0000;
    wait_sleep("R2");
    bus_start();
    send_byte({7'h27, 1'b1}, ack);
    recv_bit(bit0);
    check("R11 first bit", {31'h0, bit0}, 32'd1);
    bus_stop();
    check("R11 mid-byte stop ignored", {30'h0, mode}, 32'd2);
    read_word(7'h27, "R11 word restarts");

    begin
      logic [1:0] ta [6] = '{2'b00, 2'b00, 2'b10, 2'b10, 2'b01, 2'b01};
      logic [1:0] tb [6] = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10};
      logic [6:0] ad [6] = '{7'h14, 7'h15, 7'h17, 7'h24, 7'h26, 7'h27};
      for (int i = 0; i < 6; i++) begin
        strap_a = ta[i]; strap_b = tb[i];
        wait_sleep("R2");
        bus_start();
        send_byte({ad[i], 1'b1}, ack);
        check("R3 strap address", {31'h0, ack}, 32'd1);
        exp_q.push_back(8'hC0);
        recv_byte(1'b1, "R3 byte");
        bus_stop();
      end
    end

    strap_a = 2'b00; strap_b = 2'b00;
    wait_sleep("R2");
    bus_start();
    send_byte({7'h14, 1'b1}, ack);
    check("R3 unmapped strap pair", {31'h0, ack}, 32'd0);
    bus_stop();
    check("R3 mode kept", {30'h0, mode}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule